// File: doc/BRIEF.md
# Serial Receive Holding Register and Status

This block is the host side of a serial receiver. It sits between the receive shift register and a simple register read bus. Each completed character is captured into one holding register. The receive flags are kept in an 8-bit status word. A receive-or-break interrupt request is raised under a single enable. Bit sampling, baud timing and any FIFO logic are outside the block. Two error flags from a FIFO enter as plain inputs and are only shown on the data read.

The bus has a one-cycle read strobe `rdStb` and a 2-bit address `rdAddr`. `rdData` always shows the word at `rdAddr`, whether or not the strobe is high. The strobe only matters for its side effect, which is the clearing of the ready flag.

The stored character can be read at two addresses:
- 1 (primary): a strobed read clears the ready flag.
- 2 (alias): the ready flag is left as it is. This lets a monitor look at the character without taking it.

There is only one copy of the data behind both addresses.

Top module: `rx_char_holder`

## Requirements
- R1: Address 0 returns the status word in `rdData[7:0]`, with `rdData[15:8]` zero. Status bits are: 7 error summary, 6 data ready, 5 break, 4 framing error, 3 overrun, 2 parity error, 1 wake-up seen. Bit 0 always reads 0.
- R2: Status bit 7 is 1 exactly when any of status bits 5, 4, 3 or 2 is 1. It has no storage of its own.
- R3: A `charValid` cycle without `swRxReset` stores `charData` and sets data ready from the next cycle. In that same cycle, `charFrame`, `charParity` and `charWake` set status bits 4, 2 and 1. `breakDet` sets bit 5 in any cycle without `swRxReset`.
- R4: A strobed read at address 1 returns the character in bits 7..0 and zeros in bits 13..8. Data ready is 0 from the next cycle, unless a transfer happens in that same cycle.
- R5: A strobed read at address 2 returns the same character in bits 7..0, with bits 15..8 zero. It leaves data ready unchanged.
- R6: At address 1, bit 15 equals `fifoFrameErr` and bit 14 equals `fifoParityErr` when `fifoMode` is 1. Both bits read 0 when `fifoMode` is 0.
- R7: `rxIrq` is a registered level. It is 1 in the cycle after a cycle in which `intEna` is 1 and either data ready or break is 1. It is 0 in the cycle after the cause is gone.
- R8: A transfer that arrives while data ready is 1 sets the overrun flag (bit 3) and overwrites the held character. This also applies when a primary read happens in the same cycle.
- R9: Framing, parity, overrun, break and wake flags are sticky. A `swRxReset` cycle clears them and data ready, but keeps the held character. `swRxReset` overrides a transfer or break in the same cycle.
- R10: If a primary read and a transfer happen in the same cycle, the transfer wins and data ready stays 1.
- R11: After reset, all addresses read 0, `rxIrq` is 0, and address 3 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low system reset |
| charValid | input | 1 | One-cycle strobe: a character moves from the shift register |
| charData | input | 8 | The character being transferred |
| charFrame | input | 1 | Framing error on the character, qualified by `charValid` |
| charParity | input | 1 | Parity error on the character, qualified by `charValid` |
| charWake | input | 1 | Wake-up condition on the character, qualified by `charValid` |
| breakDet | input | 1 | Break condition seen on the line |
| swRxReset | input | 1 | Software receiver reset pulse |
| fifoMode | input | 1 | FIFO mode enabled |
| fifoFrameErr | input | 1 | FIFO framing-error flag |
| fifoParityErr | input | 1 | FIFO parity-error flag |
| intEna | input | 1 | Receive/break interrupt enable |
| rdStb | input | 1 | One-cycle read strobe |
| rdAddr | input | 2 | Read address: 0 status, 1 primary data, 2 alias data |
| rdData | output | 16 | Read data for `rdAddr` |
| rxIrq | output | 1 | Receive-or-break interrupt request |

## Verification
The assertions assume the following about the inputs:
- `charFrame`, `charParity` and `charWake` are meaningful only in a `charValid` cycle.
- `rdStb` lasts one cycle.

Under these assumptions, the set, clear and priority rules can be stated one clock at a time.

The stimulus keeps within these assumptions:
- It raises the qualifiers only together with `charValid`.
- It drops all strobes one step after the edge that consumes them.
- It keeps `intEna` steady across each vector, so the one-cycle lag of `rxIrq` can be predicted from the state alone.
- It drives overlaps (read with transfer, software reset with transfer) only as single-cycle coincidences.

// File: rtl/rx_hold_pkg.sv
package rx_hold_pkg;

  localparam int STAT_W = 8;

  // Read addresses decoded by the block.
  localparam logic [1:0] ADDR_STATUS  = 2'd0;
  localparam logic [1:0] ADDR_PRIMARY = 2'd1;
  localparam logic [1:0] ADDR_ALIAS   = 2'd2;

  // Status bit positions.
  localparam int BIT_ERR   = 7;
  localparam int BIT_READY = 6;
  localparam int BIT_BRK   = 5;
  localparam int BIT_FRAME = 4;
  localparam int BIT_OVR   = 3;
  localparam int BIT_PAR   = 2;
  localparam int BIT_WAKE  = 1;

  // Strobes from the control module to the datapath.
  typedef struct packed {
    logic loadChar;
    logic clrReady;
    logic setOverrun;
    logic setFrame;
    logic setParity;
    logic setBreak;
    logic setWake;
    logic clrFlags;
  } rxCtlT;

endpackage

// File: rtl/rx_hold_ctrl.sv
module rx_hold_ctrl
  import rx_hold_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              charValid,
  input  logic              charFrame,
  input  logic              charParity,
  input  logic              charWake,
  input  logic              breakDet,
  input  logic              swRxReset,
  input  logic              rdStb,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              intEna,
  input  logic              readyNow,
  input  logic              breakNow,
  output rxCtlT             ctl,
  output logic              rxIrq
);

  logic primaryRead;

  assign primaryRead = rdStb && (rdAddr == ADDR_W'(ADDR_PRIMARY));

  always_comb begin
    ctl = '0;
    if (swRxReset) begin
      // Software reset overrides everything else in this cycle (R9).
      ctl.clrFlags = 1'b1;
    end else begin
      ctl.loadChar   = charValid;
      ctl.setOverrun = charValid && readyNow;
      ctl.setFrame   = charValid && charFrame;
      ctl.setParity  = charValid && charParity;
      ctl.setWake    = charValid && charWake;
      ctl.setBreak   = breakDet;
      // A transfer in the same cycle wins over the clearing read (R10).
      ctl.clrReady   = primaryRead && !charValid;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxIrq <= 1'b0;
    else       rxIrq <= intEna && (readyNow || breakNow);
  end

  // R7: the request follows its causes with one register of delay
  a_r7_irq_follows: assert property (@(posedge clk) disable iff (!rstN)
    (intEna && (readyNow || breakNow)) |=> rxIrq);
  a_r7_irq_drops: assert property (@(posedge clk) disable iff (!rstN)
    !(intEna && (readyNow || breakNow)) |=> !rxIrq);

  // R9: a software reset never lets a set strobe through
  a_r9_reset_wins: assert property (@(posedge clk) disable iff (!rstN)
    swRxReset |-> !(ctl.loadChar || ctl.setBreak || ctl.setOverrun));

endmodule

// File: rtl/rx_hold_dp.sv
module rx_hold_dp
  import rx_hold_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int BUS_W    = 16,
  parameter int ADDR_W   = 2,
  parameter bit FIFO_ERR = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxCtlT             ctl,
  input  logic [DATA_W-1:0] charData,
  input  logic              fifoMode,
  input  logic              fifoFrameErr,
  input  logic              fifoParityErr,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [BUS_W-1:0]  rdData,
  output logic              readyNow,
  output logic              breakNow
);

  localparam int PAD_W = BUS_W - DATA_W - 2;

  logic [DATA_W-1:0] holdQ;
  logic readyQ, brkQ, frameQ, ovrQ, parQ, wakeQ;
  logic [STAT_W-1:0] statusW;
  logic [1:0] fifoBits;

  // Holding register: a software reset keeps the character (R9).
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             holdQ <= '0;
    else if (ctl.loadChar) holdQ <= charData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readyQ <= 1'b0;
      brkQ   <= 1'b0;
      frameQ <= 1'b0;
      ovrQ   <= 1'b0;
      parQ   <= 1'b0;
      wakeQ  <= 1'b0;
    end else if (ctl.clrFlags) begin
      readyQ <= 1'b0;
      brkQ   <= 1'b0;
      frameQ <= 1'b0;
      ovrQ   <= 1'b0;
      parQ   <= 1'b0;
      wakeQ  <= 1'b0;
    end else begin
      if (ctl.loadChar)      readyQ <= 1'b1;
      else if (ctl.clrReady) readyQ <= 1'b0;
      if (ctl.setBreak)   brkQ   <= 1'b1;
      if (ctl.setFrame)   frameQ <= 1'b1;
      if (ctl.setOverrun) ovrQ   <= 1'b1;
      if (ctl.setParity)  parQ   <= 1'b1;
      if (ctl.setWake)    wakeQ  <= 1'b1;
    end
  end

  always_comb begin
    statusW            = '0;
    statusW[BIT_READY] = readyQ;
    statusW[BIT_BRK]   = brkQ;
    statusW[BIT_FRAME] = frameQ;
    statusW[BIT_OVR]   = ovrQ;
    statusW[BIT_PAR]   = parQ;
    statusW[BIT_WAKE]  = wakeQ;
    statusW[BIT_ERR]   = brkQ | frameQ | ovrQ | parQ;
  end

  generate
    if (FIFO_ERR) begin : g_fifoErr
      assign fifoBits = fifoMode ? {fifoFrameErr, fifoParityErr} : 2'b00;
    end else begin : g_noFifoErr
      assign fifoBits = 2'b00;
    end
  endgenerate

  always_comb begin
    unique case (rdAddr)
      ADDR_W'(ADDR_STATUS):  rdData = {{(BUS_W-STAT_W){1'b0}}, statusW};
      ADDR_W'(ADDR_PRIMARY): rdData = {fifoBits, {PAD_W{1'b0}}, holdQ};
      ADDR_W'(ADDR_ALIAS):   rdData = {{(BUS_W-DATA_W){1'b0}}, holdQ};
      default:               rdData = '0;
    endcase
  end

  assign readyNow = readyQ;
  assign breakNow = brkQ;

  // R3: a load captures the character and raises ready
  a_r3_load: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadChar |=> (readyQ && holdQ == $past(charData)));
  // R8: a transfer onto a ready character flags overrun
  a_r8_overrun: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.loadChar && readyQ) |=> ovrQ);
  // R9: sticky error flags stay set until a clear strobe
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rstN)
    ((frameQ || parQ || ovrQ || brkQ) && !ctl.clrFlags)
      |=> (frameQ || parQ || ovrQ || brkQ));
  // R9: a clear strobe empties every flag but keeps the character
  a_r9_clear: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clrFlags |=> (!readyQ && !brkQ && !frameQ && !ovrQ && !parQ && !wakeQ
                      && $stable(holdQ)));
  // R4: a clearing read without a load drops ready
  a_r4_clear_ready: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.clrReady && !ctl.loadChar && !ctl.clrFlags) |=> !readyQ);

endmodule

// File: rtl/rx_char_holder.sv
module rx_char_holder
  import rx_hold_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int BUS_W    = 16,
  parameter int ADDR_W   = 2,
  parameter bit FIFO_ERR = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              charValid,
  input  logic [DATA_W-1:0] charData,
  input  logic              charFrame,
  input  logic              charParity,
  input  logic              charWake,
  input  logic              breakDet,
  input  logic              swRxReset,
  input  logic              fifoMode,
  input  logic              fifoFrameErr,
  input  logic              fifoParityErr,
  input  logic              intEna,
  input  logic              rdStb,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [BUS_W-1:0]  rdData,
  output logic              rxIrq
);

  rxCtlT ctl;
  logic  readyNow;
  logic  breakNow;

  rx_hold_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rstN(rstN),
    .charValid(charValid), .charFrame(charFrame), .charParity(charParity),
    .charWake(charWake), .breakDet(breakDet), .swRxReset(swRxReset),
    .rdStb(rdStb), .rdAddr(rdAddr), .intEna(intEna),
    .readyNow(readyNow), .breakNow(breakNow),
    .ctl(ctl), .rxIrq(rxIrq)
  );

  rx_hold_dp #(.DATA_W(DATA_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W),
               .FIFO_ERR(FIFO_ERR)) i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .charData(charData),
    .fifoMode(fifoMode), .fifoFrameErr(fifoFrameErr),
    .fifoParityErr(fifoParityErr), .rdAddr(rdAddr),
    .rdData(rdData), .readyNow(readyNow), .breakNow(breakNow)
  );

  // R5: an alias read never takes away a ready character
  a_r5_alias_keeps: assert property (@(posedge clk) disable iff (!rstN)
    (rdStb && rdAddr == ADDR_W'(ADDR_ALIAS) && readyNow && !swRxReset)
      |=> readyNow);
  // R10: a transfer beats a same-cycle primary read
  a_r10_transfer_wins: assert property (@(posedge clk) disable iff (!rstN)
    (rdStb && rdAddr == ADDR_W'(ADDR_PRIMARY) && charValid && !swRxReset)
      |=> readyNow);
  // R11: the unused address reads zero
  a_r11_unused_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddr == ADDR_W'(3)) |-> (rdData == '0));

endmodule

// File: tb/test_rx_char_holder.sv
module test_rx_char_holder;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic charValid = 0, charFrame = 0, charParity = 0, charWake = 0;
  logic breakDet = 0, swRxReset = 0, fifoMode = 0;
  logic fifoFrameErr = 0, fifoParityErr = 0, intEna = 0, rdStb = 0;
  logic [7:0]  charData = '0;
  logic [1:0]  rdAddr = '0;
  logic [15:0] rdData;
  logic        rxIrq;

  int applied = 0;
  int failed = 0;

  always #5 clk = ~clk;

  rx_char_holder i_rx_char_holder (
    .clk(clk), .rstN(rstN), .charValid(charValid), .charData(charData),
    .charFrame(charFrame), .charParity(charParity), .charWake(charWake),
    .breakDet(breakDet), .swRxReset(swRxReset), .fifoMode(fifoMode),
    .fifoFrameErr(fifoFrameErr), .fifoParityErr(fifoParityErr),
    .intEna(intEna), .rdStb(rdStb), .rdAddr(rdAddr),
    .rdData(rdData), .rxIrq(rxIrq)
  );

  typedef struct packed {
    logic       sw;
    logic       cv;
    logic [7:0] dat;
    logic       fe;
    logic       pe;
    logic       wk;
    logic       brk;
    logic       rd;
    logic [1:0] addr;
    logic       ena;
    logic [7:0] expStat;
    logic [7:0] expChar;
    logic       expIrq;
  } vecT;

  // Status bits: 7 err, 6 ready, 5 break, 4 frame, 3 overrun, 2 parity, 1 wake
  localparam int NVEC = 12;
  localparam vecT VECS [NVEC] = '{
    '{1'b0,1'b1,8'h41,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,1'b1,8'h40,8'h41,1'b1}, // R3 load
    '{1'b0,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,1'b1,2'd1,1'b1,8'h00,8'h41,1'b0}, // R4 clear
    '{1'b0,1'b1,8'h5A,1'b1,1'b0,1'b0,1'b0,1'b0,2'd0,1'b1,8'hD0,8'h5A,1'b1}, // R2 frame
    '{1'b0,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,1'b1,2'd2,1'b1,8'hD0,8'h5A,1'b1}, // R5 alias
    '{1'b0,1'b1,8'h33,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,1'b1,8'hD8,8'h33,1'b1}, // R8 overrun
    '{1'b1,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,1'b1,8'h00,8'h33,1'b0}, // R9 sw reset
    '{1'b0,1'b0,8'h00,1'b0,1'b0,1'b0,1'b1,1'b0,2'd0,1'b0,8'hA0,8'h33,1'b0}, // R7 gated
    '{1'b0,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,1'b1,8'hA0,8'h33,1'b1}, // R7 break irq
    '{1'b1,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,1'b1,8'h00,8'h33,1'b0}, // R9 clears
    '{1'b0,1'b1,8'h7E,1'b0,1'b1,1'b1,1'b0,1'b0,2'd0,1'b1,8'hC6,8'h7E,1'b1}, // R3 parity+wake
    '{1'b0,1'b1,8'h11,1'b0,1'b0,1'b0,1'b0,1'b1,2'd1,1'b1,8'hCE,8'h11,1'b1}, // R10 R8
    '{1'b1,1'b1,8'h99,1'b1,1'b0,1'b0,1'b1,1'b0,2'd0,1'b1,8'h00,8'h11,1'b0}  // R9 wins
  };

  task automatic check(input string req, input logic [15:0] act,
                       input logic [15:0] exp);
    applied++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic runVec(input vecT v, input int idx);
    charValid = v.cv; charData = v.dat; charFrame = v.fe; charParity = v.pe;
    charWake = v.wk; breakDet = v.brk; rdStb = v.rd; rdAddr = v.addr;
    swRxReset = v.sw; intEna = v.ena;
    @(posedge clk); #1;
    charValid = 0; charFrame = 0; charParity = 0; charWake = 0;
    breakDet = 0; rdStb = 0; swRxReset = 0;
    @(posedge clk); #1;
    rdAddr = 2'd0; #1;
    check($sformatf("R1/R2 status vec %0d", idx), rdData, {8'h00, v.expStat});
    rdAddr = 2'd2; #1;
    check($sformatf("R5 alias vec %0d", idx), rdData, {8'h00, v.expChar});
    check($sformatf("R7 irq vec %0d", idx), {15'd0, rxIrq}, {15'd0, v.expIrq});
  endtask

  initial begin
    #200000;
    failed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", applied, failed);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R11 reset state on every address
    for (int a = 0; a < 4; a++) begin
      rdAddr = 2'(a); #1;
      check($sformatf("R11 reset addr %0d", a), rdData, 16'h0000);
    end
    check("R11 reset irq", {15'd0, rxIrq}, 16'h0000);

    for (int i = 0; i < NVEC; i++) runVec(VECS[i], i);

    // R6: FIFO flags at primary address, gated by fifoMode
    rdAddr = 2'd1; fifoFrameErr = 1; fifoParityErr = 0; fifoMode = 1; #1;
    check("R6 fifo frame", rdData, 16'h8011);
    fifoFrameErr = 0; fifoParityErr = 1; #1;
    check("R6 fifo parity", rdData, 16'h4011);
    fifoMode = 0; fifoFrameErr = 1; #1;
    check("R6 fifo off", rdData, 16'h0011);
    rdAddr = 2'd2; fifoMode = 1; #1;
    check("R5 alias no fifo bits", rdData, 16'h0011);
    fifoMode = 0; fifoFrameErr = 0; fifoParityErr = 0;
    // R11 unused address after activity
    rdAddr = 2'd3; #1;
    check("R11 addr3", rdData, 16'h0000);
    // R4: primary read returns the character in the read cycle
    @(posedge clk); #1;
    charValid = 1; charData = 8'hC3;
    @(posedge clk); #1;
    charValid = 0; rdAddr = 2'd1; rdStb = 1; #1;
    check("R4 primary data", rdData, 16'h00C3);
    @(posedge clk); #1;
    rdStb = 0; rdAddr = 2'd0; #1;
    check("R4 ready cleared", rdData & 16'h0040, 16'h0000);
    // R1: bit 0 never set
    check("R1 bit0 zero", rdData & 16'h0001, 16'h0000);

    $display("== %0d vectors applied, %0d miscompares ==", applied, failed);
    $finish;
  end

endmodule